// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a clocked host and an asynchronous 16-bit static RAM with a 19-bit word address. The host hands over one word-sized request at a time on a valid/ready port. The block turns each request into a timed sequence on the RAM pins: two chip selects of opposite polarity, an active-low output enable, an active-low write strobe, two active-low byte-lane strobes, and a 16-bit data bus split into an output, a drive enable and an input.

Every RAM timing limit is a parameter in nanoseconds. Together with the clock period, it is turned into a whole number of cycles at elaboration by rounding up. A write first sets up the address, the selects and the lane strobes. It then pulses the write strobe low and holds the data for one extra cycle after the strobe rises. A read holds the output enable low for the full access time, captures the bus on the last cycle, and returns the word as a one-cycle response. It then leaves the bus idle for a turnaround period.

Back-pressure rules: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must hold its request fields stable while `req_valid` is high and `req_ready` is low. Responses cannot be stalled: reads complete in the order they were accepted, and each produces exactly one `rsp_valid` pulse. Writes produce no response.

Top module: `sram_ctrl`

## Requirements
- R1: After reset and whenever the block is idle, the RAM is parked: `sram_sel_n`=1, `sram_en`=0, `sram_wr_n`=1, `sram_rd_n`=1, `sram_lo_n`=1, `sram_hi_n`=1, and `sram_dq_oe`=0.
- R2: `req_ready` is 1 only in the idle state, so it is 0 during every cycle of a write or read sequence. A request held under back-pressure is taken only once the block is idle again, and it is served after the earlier request.
- R3: `sram_wr_n` goes low only while the chip is selected (`sram_sel_n`=0, `sram_en`=1), `sram_rd_n` is 1, and at least one lane strobe is low. It goes low only after one setup cycle in which the selects, address and strobes are already asserted.
- R4: A read holds both selects active, both lane strobes low and `sram_rd_n` low. It returns the full 16-bit word stored at `req_addr` on `rsp_rdata`, qualified by a one-cycle `rsp_valid` pulse.
- R5: For a write, `req_be[0]` enables the lower lane (`sram_lo_n`, data bits 7:0) and `req_be[1]` enables the upper lane (`sram_hi_n`, bits 15:8). A lane whose mask bit is 0 keeps its stored byte.
- R6: A write with `req_be`=0 is accepted but causes no pin activity: `sram_wr_n` never goes low, the RAM contents do not change, and `req_ready` is high again in the following cycle.
- R7: The write strobe stays low for exactly ceil(max(tPWE, tAW, tHZWE+tSD)/Tclk) cycles, which is 12 at the defaults. The whole write sequence lasts at least ceil(tWC/Tclk) cycles.
- R8: Write data is driven (`sram_dq_oe`=1) from the setup cycle through the cycle after `sram_wr_n` rises, so the data is valid at the edge that ends the write.
- R9: `rsp_valid` rises exactly ceil(max(tRC, tAA, tDOE)/Tclk) cycles after the accepting edge, which is 14 at the defaults. It is high for one cycle only.
- R10: The bus is never driven while `sram_rd_n` is low. After `sram_rd_n` rises, the block waits at least max(1, ceil(tHZOE/Tclk)) cycles before it drives the bus again, which is 5 at the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Write lane mask, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data |
| sram_addr | output | 19 | RAM address |
| sram_sel_n | output | 1 | Active-low chip select |
| sram_en | output | 1 | Active-high chip select |
| sram_rd_n | output | 1 | Active-low output enable |
| sram_wr_n | output | 1 | Active-low write strobe |
| sram_lo_n | output | 1 | Active-low lower-lane strobe |
| sram_hi_n | output | 1 | Active-low upper-lane strobe |
| sram_dq_o | output | 16 | Data driven to the RAM |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | 16 | Data returned from the RAM |

## Verification
The bench targets partial-lane writes and checks them by reading back. A design that swapped the lanes or ignored the mask would corrupt the neighbouring byte.

It sends a zero-mask write and counts falling edges of the write strobe. A design that pulsed the strobe anyway would change memory or add an edge. It also issues a read followed at once by a held write to the same address. A controller that reordered the two, or accepted the write early, would return the new data or lose the old.

The bench measures the strobe width, the data hold after the strobe rises, the read latency, and the idle gap between the end of a read and the next bus drive. A counter that is off by one, or a missing turnaround, shows up as a wrong count or as bus contention.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RTURN
  } st_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  st_e               st,
  input  logic [LANES-1:0]  be_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic              sel_n,
  output logic              en,
  output logic              rd_n,
  output logic              wr_n,
  output logic [LANES-1:0]  lane_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);
  logic in_wr, in_rd, selected;

  assign in_wr    = (st == ST_WSETUP) || (st == ST_WPULSE) || (st == ST_WHOLD);
  assign in_rd    = (st == ST_RACC);
  assign selected = in_wr || in_rd;

  assign sel_n = ~selected;
  assign en    = selected;
  assign rd_n  = ~in_rd;
  assign wr_n  = ~(st == ST_WPULSE);
  assign dq_oe = in_wr;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_n[i]       = ~(in_rd || (in_wr && be_q[i]));
    assign dq_o[8*i +: 8]  = in_wr ? wdata_q[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int CLK_NS = 4,
  parameter int T_RC   = 55,
  parameter int T_AA   = 55,
  parameter int T_DOE  = 25,
  parameter int T_HZOE = 20,
  parameter int T_WC   = 55,
  parameter int T_PWE  = 40,
  parameter int T_AW   = 45,
  parameter int T_HZWE = 20,
  parameter int T_SD   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_sel_n,
  output logic              sram_en,
  output logic              sram_rd_n,
  output logic              sram_wr_n,
  output logic              sram_lo_n,
  output logic              sram_hi_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int LANES = DATA_W / 8;
  localparam int N_WP  = umax(1, ns2cyc(umax(umax(T_PWE, T_AW), T_HZWE + T_SD), CLK_NS));
  localparam int N_WC  = ns2cyc(T_WC, CLK_NS);
  localparam int N_WH  = (N_WC > N_WP + 2) ? (N_WC - 1 - N_WP) : 1;
  localparam int N_RD  = umax(1, ns2cyc(umax(T_RC, umax(T_AA, T_DOE)), CLK_NS));
  localparam int N_TA  = umax(1, ns2cyc(T_HZOE, CLK_NS));
  localparam int N_MAX = umax(umax(N_WP, N_WH), umax(N_RD, N_TA));
  localparam int CNT_W = $clog2(N_MAX + 1);

  localparam logic [CNT_W-1:0] L_WP = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] L_WH = CNT_W'(N_WH - 1);
  localparam logic [CNT_W-1:0] L_RD = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] L_TA = CNT_W'(N_TA - 1);

  st_e               st, st_nxt;
  logic              t_done, t_load;
  logic [CNT_W-1:0]  t_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic [LANES-1:0]  lane_n;
  logic              take;

  assign req_ready = (st == ST_IDLE);
  assign take      = req_valid && req_ready;

  always_comb begin
    st_nxt = st;
    t_load = 1'b0;
    t_val  = '0;
    unique case (st)
      ST_IDLE: if (take) begin
        t_load = 1'b1;
        if (!req_write) begin
          st_nxt = ST_RACC;
          t_val  = L_RD;
        end else if (req_be != 2'b00) begin
          st_nxt = ST_WSETUP;
        end
      end
      ST_WSETUP: if (t_done) begin
        st_nxt = ST_WPULSE; t_load = 1'b1; t_val = L_WP;
      end
      ST_WPULSE: if (t_done) begin
        st_nxt = ST_WHOLD; t_load = 1'b1; t_val = L_WH;
      end
      ST_WHOLD: if (t_done) st_nxt = ST_IDLE;
      ST_RACC: if (t_done) begin
        st_nxt = ST_RTURN; t_load = 1'b1; t_val = L_TA;
      end
      ST_RTURN: if (t_done) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st        <= st_nxt;
      rsp_valid <= 1'b0;
      if (take) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
      if (st == ST_RACC && t_done) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= sram_dq_i;
      end
    end
  end

  sram_ctrl_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
  );

  sram_ctrl_pins #(.DATA_W(DATA_W), .LANES(LANES)) u_pins (
    .st(st), .be_q(be_q), .wdata_q(wdata_q),
    .sel_n(sram_sel_n), .en(sram_en), .rd_n(sram_rd_n), .wr_n(sram_wr_n),
    .lane_n(lane_n), .dq_o(sram_dq_o), .dq_oe(sram_dq_oe)
  );

  assign sram_addr = addr_q;
  assign sram_lo_n = lane_n[0];
  assign sram_hi_n = lane_n[1];
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic sram_sel_n,
  input logic sram_en,
  input logic sram_rd_n,
  input logic sram_wr_n,
  input logic sram_lo_n,
  input logic sram_hi_n,
  input logic sram_dq_oe
);
  assert_idle_park_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_sel_n && !sram_en && sram_wr_n && sram_rd_n &&
                   sram_lo_n && sram_hi_n && !sram_dq_oe));

  assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_we_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_wr_n |-> (!sram_sel_n && sram_en && sram_rd_n && !(sram_lo_n && sram_hi_n)));

  assert_we_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_wr_n) |-> $past(!sram_sel_n && sram_en && !(sram_lo_n && sram_hi_n)));

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!sram_wr_n) && sram_wr_n) |-> sram_dq_oe);

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_no_fight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_rd_n |-> !sram_dq_oe);

  assert_turnaround_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sram_rd_n) |-> !sram_dq_oe);
endmodule

bind sram_ctrl sram_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .sram_sel_n(sram_sel_n), .sram_en(sram_en), .sram_rd_n(sram_rd_n),
  .sram_wr_n(sram_wr_n), .sram_lo_n(sram_lo_n), .sram_hi_n(sram_hi_n),
  .sram_dq_oe(sram_dq_oe)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
  localparam int NWP = (45 + 3) / 4;
  localparam int NRD = (55 + 3) / 4;
  localparam int NTA = (20 + 3) / 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [18:0] sram_addr;
  logic sram_sel_n, sram_en, sram_rd_n, sram_wr_n, sram_lo_n, sram_hi_n, sram_dq_oe;
  logic [15:0] sram_dq_o;
  logic [15:0] sram_dq_i = '0;

  int tests = 0, fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_ctrl u_dut (.*);

  logic [15:0] ram [logic [18:0]];
  logic [15:0] refm [logic [18:0]];
  logic [15:0] exp_q [$];
  int          acc_q [$];

  function automatic logic [15:0] init_val(logic [18:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction
  function automatic logic [15:0] ram_rd(logic [18:0] a);
    return ram.exists(a) ? ram[a] : init_val(a);
  endfunction
  function automatic logic [15:0] ref_rd(logic [18:0] a);
    return refm.exists(a) ? refm[a] : init_val(a);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model and monitor, all at the falling edge
  bit   prev_wr = 0, prev_oe_low = 0, prev_setup = 0, prev_dqoe = 0;
  int   we_run = 0, we_falls = 0, oe_hi = 100;
  logic [15:0] last_d;
  logic last_lo, last_hi;
  always @(negedge clk) if (rst_n) begin
    automatic bit sel = !sram_sel_n && sram_en;
    automatic bit wr  = sel && !sram_wr_n && !(sram_lo_n && sram_hi_n);
    automatic logic [15:0] w;
    if (wr) begin
      if (!prev_wr) begin
        we_falls++;
        check(prev_setup, "R3 setup cycle before write strobe", 0, 1);
      end
      we_run++;
      last_d = sram_dq_o; last_lo = sram_lo_n; last_hi = sram_hi_n;
    end
    if (prev_wr && !wr) begin
      check(sram_dq_oe, "R8 data held after write end", sram_dq_oe, 1);
      check(we_run == NWP, "R7 write strobe width", we_run, NWP);
      w = ram_rd(sram_addr);
      if (!last_lo) w[7:0]  = last_d[7:0];
      if (!last_hi) w[15:8] = last_d[15:8];
      ram[sram_addr] = w;
      we_run = 0;
    end
    if (sram_dq_oe && !prev_dqoe)
      check(oe_hi >= NTA, "R10 turnaround before drive", oe_hi, NTA);
    if (sram_dq_oe && !sram_rd_n) check(0, "R10 bus contention", 1, 0);
    if (rsp_valid) begin
      if (exp_q.size() == 0) check(0, "R4 unexpected response", rsp_rdata, 0);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic int a = acc_q.pop_front();
        check(rsp_rdata == e, "R4 read data", rsp_rdata, e);
        check(cyc - a == NRD, "R9 read latency", cyc - a, NRD);
      end
    end
    oe_hi       = sram_rd_n ? oe_hi + 1 : 0;
    prev_setup  = sel && sram_wr_n && !(sram_lo_n && sram_hi_n);
    prev_wr     = wr;
    prev_dqoe   = sram_dq_oe;
    sram_dq_i   = 16'h0000;
    if (sel && sram_wr_n && !sram_rd_n) begin
      if (!sram_lo_n) sram_dq_i[7:0]  = ram_rd(sram_addr)[7:0];
      if (!sram_hi_n) sram_dq_i[15:8] = ram_rd(sram_addr)[15:8];
    end
  end

  task automatic send(bit wr, logic [18:0] a, logic [15:0] d, logic [1:0] be);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    if (wr) begin
      automatic logic [15:0] v = ref_rd(a);
      if (be[0]) v[7:0]  = d[7:0];
      if (be[1]) v[15:8] = d[15:8];
      refm[a] = v;
    end else begin
      exp_q.push_back(ref_rd(a));
      acc_q.push_back(cyc + 1);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    check(sram_sel_n && !sram_en && sram_wr_n && sram_rd_n && sram_lo_n &&
          sram_hi_n && !sram_dq_oe, "R1 parked in reset", 0, 1);
    rst_n = 1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", req_ready, 1);

    send(1, 19'h00010, 16'h1234, 2'b11);
    send(0, 19'h00010, 0, 0);
    drain();

    send(1, 19'h00020, 16'hAAFF, 2'b01);   // R5 lower lane only
    send(0, 19'h00020, 0, 0);
    send(1, 19'h00020, 16'h77EE, 2'b10);   // R5 upper lane only
    send(0, 19'h00020, 0, 0);
    drain();

    begin : zero_mask
      automatic int f0 = we_falls;
      send(1, 19'h00030, 16'hDEAD, 2'b00);
      check(req_ready, "R6 ready after zero-mask write", req_ready, 1);
      repeat (4) @(negedge clk);
      check(we_falls == f0, "R6 no write strobe", we_falls, f0);
      send(0, 19'h00030, 0, 0);
      drain();
    end

    // R2 back-pressure: read then held write to same address
    send(0, 19'h00040, 0, 0);
    check(!req_ready, "R2 ready low while busy", req_ready, 0);
    send(1, 19'h00040, 16'hBEEF, 2'b11);
    send(0, 19'h00040, 0, 0);
    drain();

    for (int i = 0; i < 6; i++)
      send(1, 19'(19'h7FF00 + i), 16'(16'h1111 * (i + 1)), 2'(i % 3 + 1));
    for (int i = 0; i < 6; i++) send(0, 19'(19'h7FF00 + i), 0, 0);
    send(0, 19'h7FFFF, 0, 0);
    drain();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule